// File: doc/BRIEF.md
# Two-Port Lazy-Cached Shared Memory

This block is a shared memory for two processors that gives a sequentially consistent view while letting stores take effect late. Each processor has a direct-mapped cache that covers every word, an out-queue that holds its stores, and an in-queue that holds updates waiting to be applied to its cache. A store only enters the out-queue. It reaches the backing array, and then the caches, through internal events.

The internal events are memory-write, fill, cache-update and invalidate. An external select chooses one event per cycle. The event fires only when it is enabled. Entries that come from a processor's own store carry a mark in that processor's in-queue. A read by that processor waits until every marked entry has drained, so it can never see a value older than its own store.

Top module: `lc_lazy_mem`

## Requirements
- R1: An accepted store (`wr_valid[p]` and `wr_ready[p]` high at a clock edge) is only appended to out-queue p. It changes neither the backing array nor any cache until later events move it.
- R2: `wr_ready[p]` is low while out-queue p holds QD entries. It is high when the out-queue has room, including right after reset.
- R3: A memory-write event (`evt_kind`=0, processor `evt_proc`) removes the head of that out-queue and stores its data in the backing array. It appends the pair, marked, to the issuer's in-queue and, unmarked, to the other in-queue. It is disabled (`evt_fired` low, no effect) when that out-queue is empty or when either in-queue is full.
- R4: A fill event (`evt_kind`=1) appends (`evt_addr`, current array word) unmarked to in-queue `evt_proc`. It is disabled when that in-queue is full.
- R5: A cache-update event (`evt_kind`=2) pops the head of in-queue `evt_proc`, whether marked or not, and writes it into that cache. It is disabled when the in-queue is empty.
- R6: `rd_ready[p]` is high only when `rd_valid[p]` is high, cache p holds a valid line for `rd_addr`, out-queue p is empty and in-queue p holds no marked entry. `rd_data` is then the cached word, in the same cycle.
- R7: An invalidate event (`evt_kind`=3) always fires and drops line `evt_addr` of cache `evt_proc`. Reads of that line stall until a fill and an update restore it.
- R8: After reset every word of the array is 0, both caches hold valid lines of 0 for every address, and all queues are empty.
- R9: Each mark moves with its entry as the queue shifts. A marked entry behind an unmarked one still blocks reads. An unmarked entry left after the marked ones have drained does not block reads.
- R10: At most one internal event fires per cycle. `evt_fired` is high exactly when `evt_valid` is high and the selected event is enabled.
- R11: A read by processor p of an address never returns a value older than p's own latest accepted store to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 2 | Store request, one bit per processor |
| wr_ready | output | 2 | Store accepted (out-queue has room) |
| wr_addr | input | 2*AW | Store address per processor, processor p at [p*AW +: AW] |
| wr_data | input | 2*DW | Store data per processor |
| rd_valid | input | 2 | Load request per processor |
| rd_ready | output | 2 | Load completes this cycle |
| rd_addr | input | 2*AW | Load address per processor |
| rd_data | output | 2*DW | Load data per processor, valid with rd_ready |
| evt_valid | input | 1 | Request one internal event this cycle |
| evt_kind | input | 2 | 0 memory-write, 1 fill, 2 cache-update, 3 invalidate |
| evt_proc | input | 1 | Processor whose queues or cache the event uses |
| evt_addr | input | AW | Address for fill and invalidate |
| evt_fired | output | 1 | The selected event was enabled and takes effect at this edge |

## Verification
Loads are combinational. `rd_ready` and `rd_data` are due in the same cycle as the request, so the bench drives right after a falling edge and samples 8 ns later, before the next rising edge. Stores and events act at the rising edge that follows the sample. Their effect is checked through a later load, one full cycle on. `evt_fired` and the ready signals are sampled in the same low phase in which they are requested. Expected load values are queued by the driver and compared by a monitor when the handshake completes.

// File: rtl/lc_pkg.sv
// Shared types for the lazy-cached shared memory.
package lc_pkg;
    // Internal event codes carried on evt_kind.
    typedef enum logic [1:0] {
        EV_MEMWR = 2'd0,
        EV_FILL  = 2'd1,
        EV_UPD   = 2'd2,
        EV_INVAL = 2'd3
    } lc_evt_e;
endpackage

// File: rtl/lc_shift_fifo.sv
// Shift-register FIFO. Slot 0 is always the head, and a pop shifts every
// slot down by one, so all bits of an entry (mark included) move together.
// Assumes push only when not full or when popping, and pop only when not empty.
module lc_shift_fifo #(
    parameter int W = 8,
    parameter int D = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push,
    input  logic [W-1:0]           push_data,
    input  logic                   pop,
    output logic [W-1:0]           head,
    output logic [$clog2(D+1)-1:0] count,
    output logic                   full,
    output logic                   empty
);
    localparam int CW = $clog2(D+1);

    logic [W-1:0]  slot     [D];
    logic [W-1:0]  slot_nxt [D];
    logic [CW-1:0] wr_idx;

    // Next slot contents: shift on pop, then place the pushed entry at the tail.
    always_comb begin
        for (int k = 0; k < D - 1; k++) begin
            slot_nxt[k] = pop ? slot[k+1] : slot[k];
        end
        slot_nxt[D-1] = pop ? '0 : slot[D-1];
        wr_idx = pop ? count - 1'b1 : count;
        if (push) begin
            for (int k = 0; k < D; k++) begin
                if (int'(wr_idx) == k) slot_nxt[k] = push_data;
            end
        end
    end

    // Slot and occupancy registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            for (int k = 0; k < D; k++) slot[k] <= '0;
        end else begin
            count <= count + CW'(push) - CW'(pop);
            for (int k = 0; k < D; k++) slot[k] <= slot_nxt[k];
        end
    end

    assign head  = slot[0];
    assign full  = (int'(count) == D);
    assign empty = (count == '0);
endmodule

// File: rtl/lc_cache.sv
// Direct-mapped cache with one line per address. Lines are written by
// updates and dropped by invalidates; the two never arrive in the same cycle.
// After reset every line is valid and holds 0, matching a zeroed memory.
module lc_cache #(
    parameter int AW = 2,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_en,
    input  logic [AW-1:0] upd_addr,
    input  logic [DW-1:0] upd_data,
    input  logic          inv_en,
    input  logic [AW-1:0] inv_addr,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_hit,
    output logic [DW-1:0] rd_word
);
    localparam int NW = 1 << AW;

    logic [NW-1:0] line_ok;
    logic [DW-1:0] line [NW];

    // Line valid bits and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_ok <= '1;
            for (int k = 0; k < NW; k++) line[k] <= '0;
        end else if (upd_en) begin
            line_ok[upd_addr] <= 1'b1;
            line[upd_addr]    <= upd_data;
        end else if (inv_en) begin
            line_ok[inv_addr] <= 1'b0;
        end
    end

    assign rd_hit  = line_ok[rd_addr];
    assign rd_word = line[rd_addr];
endmodule

// File: rtl/lc_lazy_mem.sv
// Two-processor shared memory with lazy caches. Stores wait in out-queues,
// and memory-write events broadcast them into in-queues, marked for the
// issuer. Cache updates apply in-queue heads. Loads are combinational and
// need a valid line, an empty out-queue and no marked in-queue entry. One
// externally selected internal event fires per cycle when it is enabled.
module lc_lazy_mem
    import lc_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 4,
    parameter int QD = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      wr_valid,
    output logic [1:0]      wr_ready,
    input  logic [2*AW-1:0] wr_addr,
    input  logic [2*DW-1:0] wr_data,
    input  logic [1:0]      rd_valid,
    output logic [1:0]      rd_ready,
    input  logic [2*AW-1:0] rd_addr,
    output logic [2*DW-1:0] rd_data,
    input  logic            evt_valid,
    input  logic [1:0]      evt_kind,
    input  logic            evt_proc,
    input  logic [AW-1:0]   evt_addr,
    output logic            evt_fired
);
    localparam int NP  = 2;
    localparam int NW  = 1 << AW;
    localparam int OW  = AW + DW;
    localparam int IW  = 1 + AW + DW;
    localparam int QCW = $clog2(QD + 1);

    logic [OW-1:0]  oq_head [NP];
    logic [IW-1:0]  iq_head [NP];
    logic [QCW-1:0] oq_cnt  [NP];
    logic [QCW-1:0] iq_cnt  [NP];
    logic [QCW-1:0] mark_cnt[NP];
    logic [NP-1:0]  oq_full, oq_empty, iq_full, iq_empty;
    logic [DW-1:0]  mem [NW];
    logic [NW*DW-1:0] mem_flat;

    lc_evt_e        kind;
    logic           ev_ok;
    logic           mw_fire, fill_fire, upd_fire, inval_fire;
    logic [AW-1:0]  mw_addr;
    logic [DW-1:0]  mw_data;

    // Decode the selected event and test whether it is enabled.
    always_comb begin
        kind = lc_evt_e'(evt_kind);
        unique case (kind)
            EV_MEMWR: ev_ok = !oq_empty[evt_proc] && (iq_full == '0);
            EV_FILL:  ev_ok = !iq_full[evt_proc];
            EV_UPD:   ev_ok = !iq_empty[evt_proc];
            default:  ev_ok = 1'b1;
        endcase
        evt_fired  = evt_valid && ev_ok;
        mw_fire    = evt_fired && (kind == EV_MEMWR);
        fill_fire  = evt_fired && (kind == EV_FILL);
        upd_fire   = evt_fired && (kind == EV_UPD);
        inval_fire = evt_fired && (kind == EV_INVAL);
        {mw_addr, mw_data} = oq_head[evt_proc];
    end

    // Backing array, written only by memory-write events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NW; k++) mem[k] <= '0;
        end else if (mw_fire) begin
            mem[mw_addr] <= mw_data;
        end
    end

    // Flat copy of the array for the checker.
    always_comb begin
        for (int k = 0; k < NW; k++) mem_flat[k*DW +: DW] = mem[k];
    end

    for (genvar p = 0; p < NP; p++) begin : g_proc
        logic          oq_push, oq_pop, iq_push, iq_pop, cu_en, ci_en, hit;
        logic [IW-1:0] iq_in;
        logic [DW-1:0] word;

        // Queue and cache controls for this processor.
        always_comb begin
            oq_push = wr_valid[p] && wr_ready[p];
            oq_pop  = mw_fire && (int'(evt_proc) == p);
            iq_push = mw_fire || (fill_fire && (int'(evt_proc) == p));
            iq_pop  = upd_fire && (int'(evt_proc) == p);
            cu_en   = iq_pop;
            ci_en   = inval_fire && (int'(evt_proc) == p);
            if (mw_fire) iq_in = {(int'(evt_proc) == p), mw_addr, mw_data};
            else         iq_in = {1'b0, evt_addr, mem[evt_addr]};
        end

        lc_shift_fifo #(.W(OW), .D(QD)) u_outq (
            .clk(clk), .rst_n(rst_n),
            .push(oq_push), .push_data({wr_addr[p*AW +: AW], wr_data[p*DW +: DW]}),
            .pop(oq_pop), .head(oq_head[p]), .count(oq_cnt[p]),
            .full(oq_full[p]), .empty(oq_empty[p])
        );

        lc_shift_fifo #(.W(IW), .D(QD)) u_inq (
            .clk(clk), .rst_n(rst_n),
            .push(iq_push), .push_data(iq_in),
            .pop(iq_pop), .head(iq_head[p]), .count(iq_cnt[p]),
            .full(iq_full[p]), .empty(iq_empty[p])
        );

        lc_cache #(.AW(AW), .DW(DW)) u_cache (
            .clk(clk), .rst_n(rst_n),
            .upd_en(cu_en), .upd_addr(iq_head[p][DW +: AW]), .upd_data(iq_head[p][DW-1:0]),
            .inv_en(ci_en), .inv_addr(evt_addr),
            .rd_addr(rd_addr[p*AW +: AW]), .rd_hit(hit), .rd_word(word)
        );

        // Count of marked in-queue entries, kept so the load check is one compare.
        always_ff @(posedge clk) begin
            if (!rst_n) mark_cnt[p] <= '0;
            else        mark_cnt[p] <= mark_cnt[p]
                                       + QCW'(iq_push && iq_in[IW-1])
                                       - QCW'(iq_pop && iq_head[p][IW-1]);
        end

        // Handshake outputs for this processor.
        always_comb begin
            wr_ready[p]          = !oq_full[p];
            rd_ready[p]          = rd_valid[p] && hit && oq_empty[p] && (mark_cnt[p] == '0);
            rd_data[p*DW +: DW]  = word;
        end
    end
endmodule

// File: rtl/lc_lazy_mem_chk.sv
// Property checker for lc_lazy_mem, attached with bind. It watches the
// handshakes, queue occupancy, mark counts and the backing array.
module lc_lazy_mem_chk #(
    parameter int AW  = 2,
    parameter int DW  = 4,
    parameter int QD  = 2,
    parameter int QCW = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [1:0]             rd_valid,
    input logic [1:0]             rd_ready,
    input logic [1:0]             wr_ready,
    input logic [1:0]             oq_empty,
    input logic [2*QCW-1:0]       oq_cnt_f,
    input logic [2*QCW-1:0]       iq_cnt_f,
    input logic [2*QCW-1:0]       mark_f,
    input logic                   mw_fire,
    input logic                   fill_fire,
    input logic                   upd_fire,
    input logic                   inval_fire,
    input logic [AW-1:0]          mw_addr,
    input logic [DW-1:0]          mw_data,
    input logic [(1<<AW)*DW-1:0]  mem_flat
);
    logic          last_mw;
    logic [AW-1:0] last_addr;
    logic [DW-1:0] last_data;

    // Remember the last memory-write so its landing can be checked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_mw   <= 1'b0;
            last_addr <= '0;
            last_data <= '0;
        end else begin
            last_mw   <= mw_fire;
            last_addr <= mw_addr;
            last_data <= mw_data;
        end
    end

    AST_MW_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        last_mw |-> (mem_flat[last_addr*DW +: DW] == last_data)); // R3

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mw_fire, fill_fire, upd_fire, inval_fire})); // R10

    for (genvar i = 0; i < 2; i++) begin : g_chk
        AST_RD_OUTQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_valid[i] && rd_ready[i]) |-> oq_empty[i]); // R6

        AST_RD_NO_MARK: assert property (@(posedge clk) disable iff (!rst_n)
            (mark_f[i*QCW +: QCW] != '0) |-> !rd_ready[i]); // R6

        AST_MARK_IN_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
            mark_f[i*QCW +: QCW] <= iq_cnt_f[i*QCW +: QCW]); // R9

        AST_WR_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(oq_cnt_f[i*QCW +: QCW]) == QD) |-> !wr_ready[i]); // R2
    end
endmodule

bind lc_lazy_mem lc_lazy_mem_chk #(.AW(AW), .DW(DW), .QD(QD), .QCW(QCW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .wr_ready(wr_ready),
    .oq_empty(oq_empty),
    .oq_cnt_f({oq_cnt[1], oq_cnt[0]}),
    .iq_cnt_f({iq_cnt[1], iq_cnt[0]}),
    .mark_f({mark_cnt[1], mark_cnt[0]}),
    .mw_fire(mw_fire), .fill_fire(fill_fire), .upd_fire(upd_fire), .inval_fire(inval_fire),
    .mw_addr(mw_addr), .mw_data(mw_data), .mem_flat(mem_flat)
);

// File: tb/tb_lc_lazy_mem.sv
// Scoreboard bench: read tasks queue expected words, and a monitor compares
// them when a load handshake completes. Drives at falling edges, samples 8 ns later.
module tb_lc_lazy_mem;
    localparam int AW = 2;
    localparam int DW = 4;
    localparam int QD = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      wr_valid = '0, wr_ready, rd_valid = '0, rd_ready;
    logic [2*AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [2*DW-1:0] wr_data = '0, rd_data;
    logic            evt_valid = 1'b0, evt_proc = 1'b0, evt_fired;
    logic [1:0]      evt_kind = '0;
    logic [AW-1:0]   evt_addr = '0;

    int total = 0;
    int bad = 0;
    int exp_q[$];
    string tag_q[$];
    logic sb_on = 1'b0;
    int   sb_p = 0;

    always #10 clk = ~clk;

    lc_lazy_mem #(.AW(AW), .DW(DW), .QD(QD)) dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_proc(evt_proc),
        .evt_addr(evt_addr), .evt_fired(evt_fired)
    );

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: compare completed loads against the scoreboard queue.
    always begin
        @(negedge clk);
        #8;
        if (sb_on && rd_valid[sb_p] && rd_ready[sb_p] && exp_q.size() > 0) begin
            check(tag_q.pop_front(), int'(rd_data[sb_p*DW +: DW]), exp_q.pop_front());
            sb_on = 1'b0;
        end
    end

    task automatic do_write(int p, int a, int d, string tag);
        int tries = 0;
        @(negedge clk);
        wr_valid[p] = 1'b1;
        wr_addr[p*AW +: AW] = AW'(a);
        wr_data[p*DW +: DW] = DW'(d);
        forever begin
            #8;
            if (wr_ready[p]) break;
            tries++;
            if (tries > 50) begin check({tag, " store never accepted"}, 0, 1); break; end
            @(negedge clk);
        end
        @(negedge clk);
        wr_valid[p] = 1'b0;
    endtask

    task automatic write_stall(int p, int a, int d, string tag);
        @(negedge clk);
        wr_valid[p] = 1'b1;
        wr_addr[p*AW +: AW] = AW'(a);
        wr_data[p*DW +: DW] = DW'(d);
        #8;
        check(tag, int'(wr_ready[p]), 0);
        @(negedge clk);
        wr_valid[p] = 1'b0;
    endtask

    task automatic event_op(int kind, int p, int a, int exp, string tag);
        @(negedge clk);
        evt_valid = 1'b1;
        evt_kind = 2'(kind);
        evt_proc = 1'(p);
        evt_addr = AW'(a);
        #8;
        check(tag, int'(evt_fired), exp);
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic do_read(int p, int a, int exp, string tag);
        int tries = 0;
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        sb_p = p;
        sb_on = 1'b1;
        rd_valid[p] = 1'b1;
        rd_addr[p*AW +: AW] = AW'(a);
        forever begin
            #8;
            if (rd_ready[p]) break;
            tries++;
            if (tries > 50) begin
                check({tag, " load never completed"}, 0, 1);
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
                sb_on = 1'b0;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        rd_valid[p] = 1'b0;
    endtask

    task automatic read_stall(int p, int a, string tag);
        @(negedge clk);
        rd_valid[p] = 1'b1;
        rd_addr[p*AW +: AW] = AW'(a);
        #8;
        check(tag, int'(rd_ready[p]), 0);
        @(negedge clk);
        rd_valid[p] = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #8;
        check("R8 wr_ready after reset", int'(wr_ready), 3);
        for (int a = 0; a < 4; a++) begin
            do_read(0, a, 0, "R8 cache0 zero");
            do_read(1, a, 0, "R8 cache1 zero");
        end

        // Store stays in the out-queue.
        do_write(0, 1, 5, "R1 store");
        read_stall(0, 1, "R6 out-queue not empty");
        do_read(1, 1, 0, "R1 other cache unchanged");
        event_op(1, 1, 1, 1, "R4 fill fires");
        event_op(2, 1, 0, 1, "R5 update fires");
        do_read(1, 1, 0, "R1 memory unchanged");

        // Memory-write and marked broadcast.
        event_op(0, 0, 0, 1, "R3 memory-write fires");
        read_stall(0, 1, "R6 marked entry blocks");
        do_read(1, 1, 0, "R3 other cache still stale");
        event_op(2, 0, 0, 1, "R5 update own");
        do_read(0, 1, 5, "R11 own store visible");
        event_op(2, 1, 0, 1, "R5 update other");
        do_read(1, 1, 5, "R3 broadcast reaches other");

        // Invalidate and refill.
        event_op(3, 0, 1, 1, "R7 invalidate fires");
        read_stall(0, 1, "R7 invalid line stalls");
        event_op(1, 0, 1, 1, "R4 fill after invalidate");
        read_stall(0, 1, "R7 fill alone not enough");
        event_op(2, 0, 0, 1, "R5 apply fill");
        do_read(0, 1, 5, "R4 fill returns memory word");

        // Out-queue full and disabled events.
        do_write(1, 2, 1, "R2 store a");
        do_write(1, 2, 2, "R2 store b");
        write_stall(1, 2, 3, "R2 full out-queue stalls");
        event_op(2, 0, 0, 0, "R10 update on empty in-queue");
        event_op(0, 0, 0, 0, "R3 memory-write with empty out-queue");
        event_op(1, 0, 0, 1, "R4 fill 1");
        event_op(1, 0, 0, 1, "R4 fill 2");
        event_op(1, 0, 0, 0, "R4 fill into full in-queue");
        event_op(0, 1, 0, 0, "R3 memory-write blocked by full in-queue");
        event_op(2, 0, 0, 1, "R5 drain 1");
        event_op(2, 0, 0, 1, "R5 drain 2");
        event_op(0, 1, 0, 1, "R3 memory-write a");
        event_op(0, 1, 0, 1, "R3 memory-write b");
        read_stall(1, 2, "R9 two marked entries block");
        event_op(2, 1, 0, 1, "R9 pop first marked");
        read_stall(1, 2, "R9 second marked still blocks");
        event_op(2, 1, 0, 1, "R9 pop second marked");
        do_read(1, 2, 2, "R11 latest own store");
        event_op(2, 0, 0, 1, "R5 other update a");
        event_op(2, 0, 0, 1, "R5 other update b");
        do_read(0, 2, 2, "R3 other sees final store");

        // Mixed marks: unmarked ahead of marked, and the reverse.
        do_write(0, 3, 7, "R9 store p0");
        do_write(1, 3, 9, "R9 store p1");
        event_op(0, 1, 0, 1, "R3 memory-write p1");
        event_op(0, 0, 0, 1, "R3 memory-write p0");
        event_op(2, 0, 0, 1, "R9 pop unmarked head");
        read_stall(0, 3, "R9 marked behind unmarked blocks");
        event_op(2, 0, 0, 1, "R9 pop marked");
        do_read(0, 3, 7, "R11 p0 own store");
        event_op(2, 1, 0, 1, "R9 pop marked head p1");
        do_read(1, 3, 9, "R9 trailing unmarked does not block");
        event_op(2, 1, 0, 1, "R5 apply trailing");
        do_read(1, 3, 7, "R3 later broadcast applied");

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule